// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns parallel words into NRZ asynchronous frames on a single line. Software writes a word into a holding register through a small register port. When the shifter is free at the next bit boundary, the word moves into the shifter and goes out least significant bit first. Because holding register and shifter are separate, the next word can be written while the current frame is still on the line, and back-to-back frames leave no gap between them.

The line rate comes from a modulus divider: one bit lasts 32 times the programmed divisor in system clocks. A control bit selects 10-bit frames or 11-bit frames. Optional even or odd parity takes the place of the most significant bit of the data field, so parity never lengthens a frame.

Two special frames exist:
- A preamble frame of all ones goes out every time the transmitter is switched on.
- While a break control is held, whole frames of zeros go out, followed by at least one mark bit.

Two flags report progress: one for "holding register empty" and one for "all shifting finished". Each has an interrupt enable, and both drive one request output.

The engine is a four-state machine:
- `TX_OFF`: disabled, line at mark.
- `TX_IDLE`: enabled, nothing to send, line at mark.
- `TX_FRAME`: a frame is being shifted.
- `TX_MARK`: the single forced mark bit after a break.

All transitions happen on a bit tick:
- From `TX_OFF`, `TX_IDLE` or `TX_MARK`, a pending preamble, break or word moves the machine to `TX_FRAME`. Otherwise the machine goes to `TX_IDLE` or `TX_OFF`, following the enable.
- From `TX_FRAME`, the end of a break frame goes to `TX_MARK`, unless another break or a preamble follows directly.
- From `TX_FRAME`, the end of any other frame either starts the next frame in `TX_FRAME` or drops to `TX_IDLE` or `TX_OFF`.

When several frames are waiting, the next one is chosen in this order: preamble first, then break, then data.

Top module: `nrz_tx`

## Requirements
- R1: After reset, `txd` is 1, status reads 0x3 (bit0 empty = 1, bit1 complete = 1), and `irq` is 0.
- R2: A data frame is sent LSB first. It is one start bit of 0, then the data field, then one stop bit of 1. With control bit2 = 0 the field is 8 bits (data[7:0]). With control bit2 = 1 the field is 9 bits (data[8:0]).
- R3: Each bit lasts 32 × divisor clocks, with the divisor at address 1. A divisor of 0 halts the bit clock: `txd` holds its value and the holding register is not moved to the shifter.
- R4: With control bit3 = 1, the most significant bit of the data field is replaced by a parity bit computed over the remaining field bits. The parity is even when control bit4 = 0 and odd when control bit4 = 1.
- R5: A write to address 0 clears the empty flag (status bit0). The flag sets when the holding register moves to the shifter. A write while the flag is clear overwrites the unsent word, and only the newest word is sent.
- R6: The complete flag (status bit1) sets when all frames, including preamble, break and the mark after a break, have finished. It is cleared only by a data write that follows a status read (rd_en at address 3) made while the flag was set. A data write without such a read leaves the flag set.
- R7: A 0→1 change of the enable bit (control bit0) queues one all-ones frame. That frame is sent before any data, and after any frame already in progress.
- R8: While the break bit (control bit1) is set, the line sends whole frames of zeros of the current frame length. A frame in progress finishes first. After the last break frame, at least one bit time of 1 is sent before a data frame.
- R9: Clearing the enable bit lets the frame in progress finish. A word still in the holding register is not sent, and `txd` then stays 1.
- R10: `irq` = (empty AND control bit5) OR (complete AND control bit6).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 data, 1 divisor, 2 control |
| wr_data | input | DIV_W | Write data |
| rd_en | input | 1 | Read strobe; at address 3 it counts as a status read |
| rd_addr | input | 2 | Read address: 0 data, 1 divisor, 2 control, 3 status |
| rd_data | output | DIV_W | Read data, combinational from `rd_addr` |
| txd | output | 1 | Serial output, 1 when idle |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are the ones where the engine must pick between competing work at a frame boundary.

- Break while data is in flight: a data frame is already on the line when break is raised, and a new word is written while the break frame runs. The break is then cleared part way through its first frame, before the frame is over. The bench measures the low run, which must be exactly one frame long, and the mark run that follows, which must be exactly one bit long.
- Overwrite: two words are written back to back just after the shifter has taken a third, so that only the newest of the two may appear.
- Halted bit clock: the divisor is set to zero with data pending, to show that nothing moves until a non-zero divisor is written.

// File: rtl/nrz_tx_pkg.sv
package nrz_tx_pkg;

    localparam int FRAME_MAX = 11;
    localparam int IDX_W     = $clog2(FRAME_MAX);
    localparam int DATA_W    = 9;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_BAUD = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    typedef enum logic [1:0] {TX_OFF, TX_IDLE, TX_FRAME, TX_MARK} tx_state_e;
    typedef enum logic [1:0] {FK_DATA, FK_PRE, FK_BRK} frame_kind_e;

    typedef struct packed {
        logic ie_cmp;
        logic ie_empty;
        logic par_odd;
        logic par_en;
        logic long_fr;
        logic brk;
        logic en;
    } tx_ctrl_t;

    // Line image of one data frame, index 0 leaves first.
    function automatic logic [FRAME_MAX-1:0] make_frame(
        input logic [DATA_W-1:0] d,
        input logic              long_fr,
        input logic              par_en,
        input logic              par_odd
    );
        logic [DATA_W-1:0] fld;
        fld = long_fr ? d : {1'b0, d[7:0]};
        if (par_en) begin
            if (long_fr) fld[8] = (^d[7:0]) ^ par_odd;
            else         fld[7] = (^d[6:0]) ^ par_odd;
        end
        return long_fr ? {1'b1, fld, 1'b0} : {2'b11, fld[7:0], 1'b0};
    endfunction

endpackage

// File: rtl/nrz_tx_baud.sv
module nrz_tx_baud #(
    parameter int DIV_W    = 13,
    parameter int PRESCALE = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int PS_W = $clog2(PRESCALE);
    localparam int CW   = DIV_W + PS_W;

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    assign limit = CW'(div) * CW'(PRESCALE) - CW'(1);
    assign tick  = (div != '0) && (cnt >= limit);

    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (div == '0 || tick)   cnt <= '0;
        else                          cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/nrz_tx_regs.sv
module nrz_tx_regs
    import nrz_tx_pkg::*;
#(
    parameter int DIV_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DIV_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [1:0]        rd_addr,
    output logic [DIV_W-1:0]  rd_data,
    input  logic              eng_load,
    input  logic              eng_took_pre,
    input  logic              eng_done,
    output tx_ctrl_t          ctrl,
    output logic [DIV_W-1:0]  baud_div,
    output logic [DATA_W-1:0] hold,
    output logic              flag_empty,
    output logic              flag_cmp,
    output logic              pre_pend,
    output logic              irq
);
    logic armed;
    logic wr_dat, wr_ctl;

    assign wr_dat = wr_en && (wr_addr == ADDR_DATA);
    assign wr_ctl = wr_en && (wr_addr == ADDR_CTRL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl       <= '0;
            baud_div   <= '0;
            hold       <= '0;
            flag_empty <= 1'b1;
            flag_cmp   <= 1'b1;
            armed      <= 1'b0;
            pre_pend   <= 1'b0;
        end else begin
            if (wr_ctl) ctrl <= tx_ctrl_t'(wr_data[6:0]);
            if (wr_en && wr_addr == ADDR_BAUD) baud_div <= wr_data;

            if (wr_ctl && wr_data[0] && !ctrl.en) pre_pend <= 1'b1;
            else if (eng_took_pre)                pre_pend <= 1'b0;

            if (wr_dat) begin
                hold       <= wr_data[DATA_W-1:0];
                flag_empty <= 1'b0;
            end else if (eng_load) begin
                flag_empty <= 1'b1;
            end

            if (wr_dat && armed) begin
                flag_cmp <= 1'b0;
                armed    <= 1'b0;
            end else begin
                if (eng_done) flag_cmp <= 1'b1;
                if (rd_en && rd_addr == ADDR_STAT && flag_cmp) armed <= 1'b1;
            end
        end
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_DATA: rd_data = DIV_W'(hold);
            ADDR_BAUD: rd_data = baud_div;
            ADDR_CTRL: rd_data = DIV_W'(ctrl);
            ADDR_STAT: rd_data = DIV_W'({flag_cmp, flag_empty});
        endcase
    end

    assign irq = (flag_empty && ctrl.ie_empty) || (flag_cmp && ctrl.ie_cmp);
endmodule

// File: rtl/nrz_tx_engine.sv
module nrz_tx_engine
    import nrz_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  logic              brk,
    input  logic              long_fr,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [DATA_W-1:0] hold,
    input  logic              have_data,
    input  logic              pre_pend,
    output logic              txd,
    output logic              load_data,
    output logic              took_pre,
    output logic              done
);
    tx_state_e            state, state_n;
    frame_kind_e          kind, pick_kind;
    logic                 pick, launch, last_bit, long_q;
    logic [FRAME_MAX-1:0] pick_bits, shreg;
    logic [IDX_W-1:0]     bitidx;

    assign last_bit = (bitidx == (long_q ? IDX_W'(FRAME_MAX-1) : IDX_W'(FRAME_MAX-2)));

    // Work selection at a frame boundary: preamble, then break, then data.
    always_comb begin
        pick      = 1'b1;
        pick_kind = FK_DATA;
        pick_bits = make_frame(hold, long_fr, par_en, par_odd);
        if (pre_pend) begin
            pick_kind = FK_PRE;
            pick_bits = '1;
        end else if (en && brk) begin
            pick_kind = FK_BRK;
            pick_bits = '0;
        end else if (!(en && have_data)) begin
            pick = 1'b0;
        end
    end

    always_comb begin
        state_n = state;
        launch  = 1'b0;
        if (tick) begin
            unique case (state)
                TX_OFF, TX_IDLE, TX_MARK: begin
                    if (pick) begin
                        launch  = 1'b1;
                        state_n = TX_FRAME;
                    end else begin
                        state_n = en ? TX_IDLE : TX_OFF;
                    end
                end
                TX_FRAME: begin
                    if (last_bit) begin
                        if (kind == FK_BRK && !(pick && pick_kind != FK_DATA)) begin
                            state_n = TX_MARK;
                        end else if (pick) begin
                            launch  = 1'b1;
                            state_n = TX_FRAME;
                        end else begin
                            state_n = en ? TX_IDLE : TX_OFF;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= TX_OFF;
            kind   <= FK_DATA;
            shreg  <= '1;
            bitidx <= '0;
            long_q <= 1'b0;
        end else begin
            state <= state_n;
            if (launch) begin
                shreg  <= pick_bits;
                bitidx <= '0;
                kind   <= pick_kind;
                long_q <= long_fr;
            end else if (tick && state == TX_FRAME) begin
                shreg  <= {1'b1, shreg[FRAME_MAX-1:1]};
                bitidx <= bitidx + IDX_W'(1);
            end
        end
    end

    always_comb begin
        txd       = (state == TX_FRAME) ? shreg[0] : 1'b1;
        load_data = launch && (pick_kind == FK_DATA);
        took_pre  = launch && (pick_kind == FK_PRE);
        done      = tick && !launch && (state_n != TX_MARK) &&
                    (state == TX_MARK || (state == TX_FRAME && last_bit));
    end
endmodule

// File: rtl/nrz_tx.sv
module nrz_tx
    import nrz_tx_pkg::*;
#(
    parameter int DIV_W    = 13,
    parameter int PRESCALE = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [DIV_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [1:0]       rd_addr,
    output logic [DIV_W-1:0] rd_data,
    output logic             txd,
    output logic             irq
);
    tx_ctrl_t          ctrl;
    logic [DIV_W-1:0]  baud_div;
    logic [DATA_W-1:0] hold;
    logic              flag_empty, flag_cmp, pre_pend;
    logic              baud_tick, eng_load, eng_took_pre, eng_done;

    nrz_tx_baud #(.DIV_W(DIV_W), .PRESCALE(PRESCALE)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .div  (baud_div),
        .tick (baud_tick)
    );

    nrz_tx_regs #(.DIV_W(DIV_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .eng_load    (eng_load),
        .eng_took_pre(eng_took_pre),
        .eng_done    (eng_done),
        .ctrl        (ctrl),
        .baud_div    (baud_div),
        .hold        (hold),
        .flag_empty  (flag_empty),
        .flag_cmp    (flag_cmp),
        .pre_pend    (pre_pend),
        .irq         (irq)
    );

    nrz_tx_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .en       (ctrl.en),
        .brk      (ctrl.brk),
        .long_fr  (ctrl.long_fr),
        .par_en   (ctrl.par_en),
        .par_odd  (ctrl.par_odd),
        .hold     (hold),
        .have_data(!flag_empty),
        .pre_pend (pre_pend),
        .txd      (txd),
        .load_data(eng_load),
        .took_pre (eng_took_pre),
        .done     (eng_done)
    );
endmodule

// File: rtl/nrz_tx_chk.sv
module nrz_tx_chk
    import nrz_tx_pkg::*;
#(
    parameter int DIV_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             txd,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [DIV_W-1:0] baud_div,
    input logic             flag_empty,
    input logic             flag_cmp,
    input logic             baud_tick,
    input logic             eng_load,
    input logic             eng_done
);
    assert_halted_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_div == '0) |=> $stable(txd));

    assert_fall_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txd) |-> $past(baud_tick));

    assert_empty_from_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_empty) |-> $past(eng_load));

    assert_write_clears_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_DATA) |=> !flag_empty);

    assert_complete_from_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_cmp) |-> $past(eng_done));
endmodule

bind nrz_tx nrz_tx_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .txd       (txd),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .baud_div  (baud_div),
    .flag_empty(flag_empty),
    .flag_cmp  (flag_cmp),
    .baud_tick (baud_tick),
    .eng_load  (eng_load),
    .eng_done  (eng_done)
);

// File: tb/tb_nrz_tx.sv
module tb_nrz_tx;
    localparam int DW = 13;
    localparam logic [11:0] VECS [6] = '{12'h0A5, 12'h453, 12'h67F, 12'h9C3, 12'hCF0, 12'hFFF};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [1:0]    rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          txd, irq;

    int n_vec = 0, n_bad = 0, cyc = 0;
    int low_cnt = 0, high_cnt = 0, last_low = 0, last_high = 0, falls = 0;

    always #5 clk = ~clk;

    nrz_tx dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
                .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .txd(txd), .irq(irq));

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            n_bad++;
            $display("FAIL watchdog all requirements: cycles=%0d expected below %0d", cyc, 190000);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (txd === 1'b0) begin
                if (high_cnt != 0) begin last_high = high_cnt; falls++; end
                high_cnt = 0; low_cnt++;
            end else begin
                if (low_cnt != 0) last_low = low_cnt;
                low_cnt = 0; high_cnt++;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input int v);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = DW'(v);
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic stat_rd(output logic [DW-1:0] v);
        @(negedge clk); rd_en = 1'b1; rd_addr = 2'd3; #1 v = rd_data;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic stat_peek(output logic [DW-1:0] v);
        rd_addr = 2'd3; #1 v = rd_data;
    endtask

    task automatic wait_stat_bit(input int b);
        logic [DW-1:0] s;
        for (int t = 0; t < 20000; t++) begin
            @(negedge clk); stat_peek(s);
            if (s[b]) break;
        end
    endtask

    task automatic rx_frame(input int div, input int nb, output logic [10:0] bits);
        int t = 0;
        bits = '1;
        while (txd !== 1'b0 && t < 20000) begin @(negedge clk); t++; end
        if (t >= 20000) begin bits = '0; return; end
        repeat (16 * div - 1) @(negedge clk);
        bits[0] = txd;
        for (int i = 1; i < nb; i++) begin
            repeat (32 * div) @(negedge clk);
            bits[i] = txd;
        end
    endtask

    function automatic logic [10:0] exp_frame(input logic lf, input logic pe, input logic po,
                                              input logic [8:0] d);
        int w;
        logic [10:0] f;
        logic p;
        w = lf ? 9 : 8;
        f = '1;
        f[0] = 1'b0;
        for (int i = 0; i < w; i++) f[1 + i] = d[i];
        if (pe) begin
            p = po;
            for (int i = 0; i < w - 1; i++) p = p ^ d[i];
            f[w] = p;
        end
        f[w + 1] = 1'b1;
        return f;
    endfunction

    initial begin
        logic [DW-1:0] s;
        logic [10:0]   b;
        int            t0, f0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        stat_peek(s);
        check("R1 txd after reset", int'(txd), 1);
        check("R1 status after reset", int'(s), 3);
        check("R1 irq after reset", int'(irq), 0);

        // R7 preamble on enable, data waits one idle frame
        reg_wr(2'd1, 1);
        stat_rd(s);
        reg_wr(2'd0, 'h0A5);
        stat_peek(s);
        check("R6 complete cleared by read then write", int'(s[1]), 0);
        reg_wr(2'd2, 1);
        t0 = cyc;
        while (txd !== 1'b0 && cyc < t0 + 5000) @(negedge clk);
        check("R7 preamble delay within [320,352]",
              int'((cyc - t0) >= 320 && (cyc - t0) <= 352), 1);
        rx_frame(1, 10, b);
        check("R2 first frame after preamble", int'(b), int'(exp_frame(1'b0, 1'b0, 1'b0, 9'h0A5)));
        wait_stat_bit(1);

        // R2 R4 vector table
        for (int i = 0; i < 6; i++) begin
            logic lf, pe, po;
            logic [8:0] d;
            {lf, pe, po, d} = VECS[i];
            reg_wr(2'd2, 1 | (int'(lf) << 2) | (int'(pe) << 3) | (int'(po) << 4));
            stat_rd(s);
            reg_wr(2'd0, int'(d));
            rx_frame(1, lf ? 11 : 10, b);
            check($sformatf("R2 R4 vector %0d frame", i), int'(b), int'(exp_frame(lf, pe, po, d)));
            wait_stat_bit(1);
            stat_peek(s);
            check($sformatf("R6 vector %0d complete", i), int'(s[1]), 1);
        end

        // R3 bit length with divisor 3: start + bit0 low = 2 bits
        reg_wr(2'd2, 1);
        reg_wr(2'd1, 3);
        reg_wr(2'd0, 'h0FE);
        wait_stat_bit(0);
        repeat (3200) @(negedge clk);
        check("R3 two-bit low run at divisor 3", last_low, 192);

        // R3 divisor zero halts
        reg_wr(2'd1, 0);
        reg_wr(2'd0, 'h05A);
        f0 = falls;
        repeat (2000) @(negedge clk);
        check("R3 no falling edge with divisor 0", falls - f0, 0);
        stat_peek(s);
        check("R3 holding kept with divisor 0", int'(s[0]), 0);
        reg_wr(2'd1, 1);
        rx_frame(1, 10, b);
        check("R3 frame after divisor restored", int'(b), int'(exp_frame(1'b0, 1'b0, 1'b0, 9'h05A)));
        wait_stat_bit(1);

        // R5 overwrite of unsent word
        reg_wr(2'd0, 'h011);
        wait_stat_bit(0);
        reg_wr(2'd0, 'h022);
        reg_wr(2'd0, 'h033);
        rx_frame(1, 10, b);
        check("R5 word in shifter", int'(b), int'(exp_frame(1'b0, 1'b0, 1'b0, 9'h011)));
        rx_frame(1, 10, b);
        check("R5 newest word replaces unsent", int'(b), int'(exp_frame(1'b0, 1'b0, 1'b0, 9'h033)));
        wait_stat_bit(1);

        // R6 write without status read keeps complete
        reg_wr(2'd0, 'h044);
        stat_peek(s);
        check("R6 complete kept without read", int'(s[1]), 1);
        repeat (400) @(negedge clk);
        stat_rd(s);
        reg_wr(2'd0, 'h055);
        stat_peek(s);
        check("R6 complete cleared after read", int'(s[1]), 0);
        wait_stat_bit(1);
        stat_peek(s);
        check("R6 complete set at end", int'(s[1]), 1);

        // R8 break after frame in progress, then mark before data
        reg_wr(2'd0, 'h00F);
        wait_stat_bit(0);
        reg_wr(2'd2, 3);
        rx_frame(1, 10, b);
        check("R8 frame in progress finishes", int'(b), int'(exp_frame(1'b0, 1'b0, 1'b0, 9'h00F)));
        t0 = cyc;
        while (txd !== 1'b0 && cyc < t0 + 2000) @(negedge clk);
        repeat (200) @(negedge clk);
        reg_wr(2'd0, 'h066);
        reg_wr(2'd2, 1);
        t0 = cyc;
        while (txd !== 1'b1 && cyc < t0 + 2000) @(negedge clk);
        @(negedge clk);
        check("R8 break is one whole frame", last_low, 320);
        t0 = cyc;
        while (txd !== 1'b0 && cyc < t0 + 2000) @(negedge clk);
        @(negedge clk);
        check("R8 mark bit after break", last_high, 32);
        rx_frame(1, 10, b);
        check("R8 data after break", int'(b), int'(exp_frame(1'b0, 1'b0, 1'b0, 9'h066)));
        wait_stat_bit(1);

        // R9 disable: current frame ends, held word not sent
        reg_wr(2'd0, 'h077);
        wait_stat_bit(0);
        reg_wr(2'd0, 'h088);
        reg_wr(2'd2, 0);
        rx_frame(1, 10, b);
        check("R9 frame in progress finishes", int'(b), int'(exp_frame(1'b0, 1'b0, 1'b0, 9'h077)));
        f0 = falls;
        repeat (1000) @(negedge clk);
        check("R9 no frame after disable", falls - f0, 0);
        stat_peek(s);
        check("R9 held word stays unsent", int'(s[0]), 0);

        // R10 interrupt combination (empty=0, complete=1 now)
        reg_wr(2'd2, 1 << 5);
        check("R10 irq empty-enable with empty clear", int'(irq), 0);
        reg_wr(2'd2, 1 << 6);
        check("R10 irq complete-enable with complete set", int'(irq), 1);
        reg_wr(2'd2, 1 | (1 << 5));
        wait_stat_bit(0);
        @(negedge clk);
        check("R10 irq empty-enable with empty set", int'(irq), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule